// File: doc/BRIEF.md
# Full-Map Directory Coherence Controller

This block sits at the home node of a small distributed shared memory system. It owns a slice of memory blocks. For each block it keeps a directory entry: a presence vector with one bit per processor node, and a state that is uncached, shared or modified. Node caches send it their misses and their write-backs over a request channel. The controller answers each miss with a data grant on a command channel. Before granting, it may have to invalidate remote copies or pull modified data back from the owning cache. The caches answer those commands on a response channel.

The block handles one transaction at a time. While a transaction is in flight, `req_ready` is low and new requests wait at the channel. Memory contents and directory entries are held in internal registers and reset to zero and uncached.

Encodings:
- Request kinds: read miss = 0, write miss = 1, write-back = 2.
- Command kinds: invalidate = 0, fetch (owner keeps a shared copy) = 1, fetch-and-invalidate = 2, shared grant = 3, exclusive grant = 4.
- Response kinds: invalidate acknowledge = 0, returned data = 1.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid` is 0. Every block reads as uncached with memory value 0.
- R2: A read miss (kind 0) to an uncached or shared block produces exactly one shared grant (command 3) to the requester. The grant carries the memory value and issues no invalidate or fetch. The requester is then recorded as a sharer.
- R3: A write miss (kind 1) to an uncached block produces one exclusive grant (command 4) to the requester, carrying the memory value, with no invalidate or fetch.
- R4: A write miss to a shared block sends one invalidate (command 0) to every sharer other than the requester. Invalidates go out one per cycle, in ascending node order, and no node receives more than one.
- R5: The exclusive grant for a write miss to a shared block is issued only after an acknowledge (response 0) has arrived for every invalidate sent. The requester then becomes the sole holder, in the modified state.
- R6: A read miss to a modified block sends a fetch (command 1) to the owner. The returned data (response 1) is written to memory, and the requester receives a shared grant carrying it. Both the old owner and the requester are then sharers.
- R7: A write miss to a modified block sends a fetch-and-invalidate (command 2) to the owner. The requester receives an exclusive grant with the returned data and becomes the only holder.
- R8: A write-back (kind 2) from the owner of a modified block stores its data in memory and returns the entry to uncached with no presence bits. No command is issued.
- R9: A write-back from a node that is not the owner of a modified block is ignored. Memory and directory are unchanged, and no command is issued.
- R10: Once a miss is accepted, `req_ready` stays 0 until the grant cycle has passed, so only one transaction is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_type | input | 2 | Request kind |
| req_node | input | log2(NODES) | Requesting node |
| req_block | input | log2(BLOCKS) | Target block |
| req_data | input | DATA_W | Write-back data |
| cmd_valid | output | 1 | Command present (always accepted) |
| cmd_type | output | 3 | Command kind |
| cmd_node | output | log2(NODES) | Destination node |
| cmd_block | output | log2(BLOCKS) | Block concerned |
| cmd_data | output | DATA_W | Grant data |
| rsp_valid | input | 1 | Response present |
| rsp_type | input | 1 | Response kind |
| rsp_node | input | log2(NODES) | Responding node |
| rsp_data | input | DATA_W | Returned block data |

## Verification
The checks assume the following about the caches:
- A cache accepts every command at once.
- A cache sends an acknowledge only for an invalidate it received, and data only for a fetch addressed to it.
- At most one response arrives per cycle.
- A cache never misses on a block it already holds.

The bench's cache model answers each command exactly once, one cycle later. Because invalidates leave the controller one per cycle, their acknowledges never collide. The request generator skips any miss that a holding node would not make. It deliberately includes write-backs from non-owners, since the controller must tolerate them.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        REQ_RD = 2'd0,
        REQ_WR = 2'd1,
        REQ_WB = 2'd2
    } req_kind_e;

    typedef enum logic [2:0] {
        CMD_INV       = 3'd0,
        CMD_FETCH     = 3'd1,
        CMD_FETCH_INV = 3'd2,
        CMD_GRANT_S   = 3'd3,
        CMD_GRANT_M   = 3'd4
    } cmd_kind_e;

    typedef enum logic {
        RSP_ACK  = 1'b0,
        RSP_DATA = 1'b1
    } rsp_kind_e;

    typedef enum logic [1:0] {
        DIR_UNC = 2'd0,
        DIR_SH  = 2'd1,
        DIR_MOD = 2'd2
    } dir_state_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT_DATA,
        ST_INV,
        ST_WAIT_ACK,
        ST_GRANT
    } ctl_state_e;

endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(BLOCKS)-1:0]   rd_blk,
    output dir_state_e                  rd_state,
    output logic [NODES-1:0]            rd_bits,
    output logic [DATA_W-1:0]           rd_data,
    input  logic [$clog2(BLOCKS)-1:0]   wr_blk,
    input  logic                        dir_we,
    input  dir_state_e                  wr_state,
    input  logic [NODES-1:0]            wr_bits,
    input  logic                        mem_we,
    input  logic [DATA_W-1:0]           wr_data
);
    localparam int BLK_W = $clog2(BLOCKS);

    dir_state_e          st_q   [BLOCKS];
    logic [NODES-1:0]    bits_q [BLOCKS];
    logic [DATA_W-1:0]   data_q [BLOCKS];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[b]   <= DIR_UNC;
                bits_q[b] <= '0;
                data_q[b] <= '0;
            end else begin
                if (dir_we && wr_blk == BLK_W'(b)) begin
                    st_q[b]   <= wr_state;
                    bits_q[b] <= wr_bits;
                end
                if (mem_we && wr_blk == BLK_W'(b)) begin
                    data_q[b] <= wr_data;
                end
            end
        end
    end

    assign rd_state = st_q[rd_blk];
    assign rd_bits  = bits_q[rd_blk];
    assign rd_data  = data_q[rd_blk];

endmodule

// File: rtl/dir_pick_lowest.sv
module dir_pick_lowest #(
    parameter int N = 4
) (
    input  logic [N-1:0]           mask,
    output logic                   any,
    output logic [$clog2(N)-1:0]   idx,
    output logic [N-1:0]           onehot
);
    localparam int IDX_W = $clog2(N);

    always_comb begin
        any    = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                any       = 1'b1;
                idx       = IDX_W'(i);
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [1:0]                  req_type,
    input  logic [$clog2(NODES)-1:0]    req_node,
    input  logic [$clog2(BLOCKS)-1:0]   req_block,
    input  logic [DATA_W-1:0]           req_data,
    output logic                        cmd_valid,
    output logic [2:0]                  cmd_type,
    output logic [$clog2(NODES)-1:0]    cmd_node,
    output logic [$clog2(BLOCKS)-1:0]   cmd_block,
    output logic [DATA_W-1:0]           cmd_data,
    input  logic                        rsp_valid,
    input  logic                        rsp_type,
    input  logic [$clog2(NODES)-1:0]    rsp_node,
    input  logic [DATA_W-1:0]           rsp_data
);
    localparam int NODE_W = $clog2(NODES);
    localparam int BLK_W  = $clog2(BLOCKS);

    ctl_state_e            st_q, st_d;
    req_kind_e             kind_q;
    logic [NODE_W-1:0]     node_q;
    logic [BLK_W-1:0]      blk_q;
    logic [NODE_W-1:0]     owner_q, owner_d;
    logic [NODES-1:0]      pend_q, pend_d;
    logic [NODES-1:0]      wait_q, wait_d;

    logic [BLK_W-1:0]      rd_blk, wr_blk;
    dir_state_e            rd_state, wr_state;
    logic [NODES-1:0]      rd_bits, wr_bits;
    logic [DATA_W-1:0]     rd_data, wr_data;
    logic                  dir_we, mem_we;

    logic                  accept;
    req_kind_e             req_kind;
    logic [NODES-1:0]      req_oh, cur_oh, rsp_oh, others;

    logic                  own_any, inv_any;
    logic [NODE_W-1:0]     own_idx, inv_idx;
    logic [NODES-1:0]      own_oh, inv_oh;

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign req_kind  = req_kind_e'(req_type);
    assign req_oh    = NODES'(1) << req_node;
    assign cur_oh    = NODES'(1) << node_q;
    assign rsp_oh    = NODES'(1) << rsp_node;
    assign others    = rd_bits & ~req_oh;
    assign rd_blk    = (st_q == ST_IDLE) ? req_block : blk_q;
    assign wr_blk    = rd_blk;

    dir_entry_store #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_blk   (rd_blk),
        .rd_state (rd_state),
        .rd_bits  (rd_bits),
        .rd_data  (rd_data),
        .wr_blk   (wr_blk),
        .dir_we   (dir_we),
        .wr_state (wr_state),
        .wr_bits  (wr_bits),
        .mem_we   (mem_we),
        .wr_data  (wr_data)
    );

    // Owner of a modified entry: its single presence bit.
    dir_pick_lowest #(.N(NODES)) u_owner (
        .mask   (rd_bits),
        .any    (own_any),
        .idx    (own_idx),
        .onehot (own_oh)
    );

    // Next sharer to invalidate, lowest index first.
    dir_pick_lowest #(.N(NODES)) u_inv (
        .mask   (pend_q),
        .any    (inv_any),
        .idx    (inv_idx),
        .onehot (inv_oh)
    );

    always_comb begin
        st_d      = st_q;
        owner_d   = owner_q;
        pend_d    = pend_q;
        wait_d    = wait_q;
        dir_we    = 1'b0;
        mem_we    = 1'b0;
        wr_state  = DIR_UNC;
        wr_bits   = '0;
        wr_data   = '0;
        cmd_valid = 1'b0;
        cmd_type  = CMD_INV;
        cmd_node  = node_q;

        if (rsp_valid && rsp_type == RSP_ACK) begin
            wait_d = wait_q & ~rsp_oh;
        end

        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    owner_d = own_idx;
                    case (req_kind)
                        REQ_WB: begin
                            if (rd_state == DIR_MOD && (rd_bits & req_oh) != '0) begin
                                dir_we   = 1'b1;
                                wr_state = DIR_UNC;
                                wr_bits  = '0;
                                mem_we   = 1'b1;
                                wr_data  = req_data;
                            end
                        end
                        REQ_RD: begin
                            st_d = (rd_state == DIR_MOD && own_any) ? ST_FETCH : ST_GRANT;
                        end
                        REQ_WR: begin
                            if (rd_state == DIR_MOD && own_any) begin
                                st_d = ST_FETCH;
                            end else if (rd_state == DIR_SH && others != '0) begin
                                pend_d = others;
                                wait_d = others;
                                st_d   = ST_INV;
                            end else begin
                                st_d = ST_GRANT;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_FETCH: begin
                cmd_valid = 1'b1;
                cmd_type  = (kind_q == REQ_RD) ? CMD_FETCH : CMD_FETCH_INV;
                cmd_node  = owner_q;
                st_d      = ST_WAIT_DATA;
            end
            ST_WAIT_DATA: begin
                if (rsp_valid && rsp_type == RSP_DATA && rsp_node == owner_q) begin
                    mem_we  = 1'b1;
                    wr_data = rsp_data;
                    st_d    = ST_GRANT;
                end
            end
            ST_INV: begin
                cmd_valid = inv_any;
                cmd_type  = CMD_INV;
                cmd_node  = inv_idx;
                pend_d    = pend_q & ~inv_oh;
                if (pend_d == '0) begin
                    st_d = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (wait_q == '0) begin
                    st_d = ST_GRANT;
                end
            end
            ST_GRANT: begin
                cmd_valid = 1'b1;
                cmd_node  = node_q;
                dir_we    = 1'b1;
                if (kind_q == REQ_RD) begin
                    cmd_type = CMD_GRANT_S;
                    wr_state = DIR_SH;
                    wr_bits  = rd_bits | cur_oh;
                end else begin
                    cmd_type = CMD_GRANT_M;
                    wr_state = DIR_MOD;
                    wr_bits  = cur_oh;
                end
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign cmd_block = blk_q;
    assign cmd_data  = rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            kind_q  <= REQ_RD;
            node_q  <= '0;
            blk_q   <= '0;
            owner_q <= '0;
            pend_q  <= '0;
            wait_q  <= '0;
        end else begin
            st_q    <= st_d;
            owner_q <= owner_d;
            pend_q  <= pend_d;
            wait_q  <= wait_d;
            if (accept) begin
                kind_q <= req_kind;
                node_q <= req_node;
                blk_q  <= req_block;
            end
        end
    end

endmodule

// File: rtl/dir_coherence_ctrl_chk.sv
module dir_coherence_ctrl_chk #(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic [1:0]                  req_type,
    input logic [$clog2(NODES)-1:0]    req_node,
    input logic [$clog2(BLOCKS)-1:0]   req_block,
    input logic                        cmd_valid,
    input logic [2:0]                  cmd_type,
    input logic [$clog2(NODES)-1:0]    cmd_node,
    input logic [$clog2(BLOCKS)-1:0]   cmd_block,
    input logic                        rsp_valid,
    input logic                        rsp_type
);
    localparam int NODE_W = $clog2(NODES);
    localparam int BLK_W  = $clog2(BLOCKS);
    localparam int CNT_W  = $clog2(NODES) + 2;

    logic [NODE_W-1:0] lat_node;
    logic [BLK_W-1:0]  lat_blk;
    logic [CNT_W-1:0]  inv_out;
    logic              inv_inc, ack_dec;

    assign inv_inc = cmd_valid && cmd_type == 3'd0;
    assign ack_dec = rsp_valid && rsp_type == 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_node <= '0;
            lat_blk  <= '0;
            inv_out  <= '0;
        end else begin
            if (req_valid && req_ready) begin
                lat_node <= req_node;
                lat_blk  <= req_block;
            end
            inv_out <= inv_out + CNT_W'(inv_inc) - CNT_W'(ack_dec);
        end
    end

    // R10: an accepted miss makes the controller busy on the next cycle
    a_r10_busy_after_miss: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_type != 2'd2) |=> !req_ready);

    // R8 / R9: a write-back never triggers a command
    a_r8_wb_silent: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_type == 2'd2) |=> !cmd_valid);

    // R5: no exclusive grant while invalidates are unacknowledged
    a_r5_grant_after_acks: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_type == 3'd4) |-> inv_out == '0);

    // R4: the requester is never sent an invalidate
    a_r4_inv_not_requester: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_type == 3'd0) |-> cmd_node != lat_node);

    // R2: grants go to the requester for the requested block
    a_r2_grant_target: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_type == 3'd3 || cmd_type == 3'd4))
            |-> (cmd_node == lat_node && cmd_block == lat_blk));

endmodule

bind dir_coherence_ctrl dir_coherence_ctrl_chk #(
    .NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_type  (req_type),
    .req_node  (req_node),
    .req_block (req_block),
    .cmd_valid (cmd_valid),
    .cmd_type  (cmd_type),
    .cmd_node  (cmd_node),
    .cmd_block (cmd_block),
    .rsp_valid (rsp_valid),
    .rsp_type  (rsp_type)
);

// File: tb/dir_coherence_ctrl_tb_top.sv
module dir_coherence_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NODES  = 4;
    localparam int BLOCKS = 8;
    localparam int DATA_W = 16;
    localparam int NW = $clog2(NODES);
    localparam int BW = $clog2(BLOCKS);
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_type = '0;
    logic [NW-1:0] req_node = '0;
    logic [BW-1:0] req_block = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic cmd_valid;
    logic [2:0] cmd_type;
    logic [NW-1:0] cmd_node;
    logic [BW-1:0] cmd_block;
    logic [DATA_W-1:0] cmd_data;
    logic rsp_valid = 1'b0, rsp_type = 1'b0;
    logic [NW-1:0] rsp_node = '0;
    logic [DATA_W-1:0] rsp_data = '0;

    dir_coherence_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_node(req_node), .req_block(req_block), .req_data(req_data),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_node(cmd_node),
        .cmd_block(cmd_block), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_node(rsp_node),
        .rsp_data(rsp_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // reference model: 0 uncached, 1 shared, 2 modified
    int               m_state [BLOCKS];
    logic [NODES-1:0] m_bits  [BLOCKS];
    logic [DATA_W-1:0] m_mem  [BLOCKS];
    logic [DATA_W-1:0] cval   [NODES][BLOCKS];

    // observation of one transaction
    logic [NODES-1:0] obs_inv;
    int  obs_fetch, obs_fnode, obs_gtype, obs_gnode, last_inv;
    logic [DATA_W-1:0] obs_gdata;
    bit  obs_grant, obs_any, order_err, ready_err, busy;
    int  grant_cyc, last_ack_cyc, ack_cnt;

    // pending response of the cache model
    bit p_valid = 1'b0;
    logic p_type = 1'b0;
    logic [NW-1:0] p_node = '0;
    logic [DATA_W-1:0] p_data = '0;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
            summary();
            $finish;
        end
    end

    // cache model and monitor
    always @(negedge clk) begin
        if (rst) begin
            rsp_valid = 1'b0;
            p_valid   = 1'b0;
        end else begin
            rsp_valid = p_valid;
            rsp_type  = p_type;
            rsp_node  = p_node;
            rsp_data  = p_data;
            if (p_valid && p_type == 1'b0) begin
                last_ack_cyc = cyc;
                ack_cnt++;
            end
            p_valid = 1'b0;
            if (busy && !obs_grant && req_ready) ready_err = 1'b1;
            if (cmd_valid) begin
                obs_any = 1'b1;
                case (cmd_type)
                    3'd0: begin
                        if (int'(cmd_node) <= last_inv || obs_inv[cmd_node]) order_err = 1'b1;
                        last_inv = int'(cmd_node);
                        obs_inv[cmd_node] = 1'b1;
                        p_valid = 1'b1; p_type = 1'b0; p_node = cmd_node; p_data = '0;
                    end
                    3'd1, 3'd2: begin
                        obs_fetch = int'(cmd_type);
                        obs_fnode = int'(cmd_node);
                        p_valid = 1'b1; p_type = 1'b1; p_node = cmd_node;
                        p_data = cval[cmd_node][cmd_block];
                    end
                    3'd3, 3'd4: begin
                        obs_grant = 1'b1;
                        obs_gtype = int'(cmd_type);
                        obs_gnode = int'(cmd_node);
                        obs_gdata = cmd_data;
                        grant_cyc = cyc;
                    end
                    default: order_err = 1'b1;
                endcase
            end
        end
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int lowest(logic [NODES-1:0] m);
        for (int i = NODES - 1; i >= 0; i--) ;
        for (int i = 0; i < NODES; i++) if (m[i]) return i;
        return 0;
    endfunction

    task automatic txn(int kind, int node, int blk, logic [DATA_W-1:0] d);
        int st = m_state[blk];
        logic [NODES-1:0] bits = m_bits[blk];
        logic [NODES-1:0] me = NODES'(1) << node;
        int owner = lowest(bits);
        logic [NODES-1:0] exp_inv = '0;
        int exp_fk = 0;
        int exp_gt;
        logic [DATA_W-1:0] exp_gd;
        string tag;
        int n;
        bit legal_wb = (st == 2) && bits[node];

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        obs_inv = '0; obs_fetch = 0; obs_fnode = 0; obs_grant = 1'b0; obs_any = 1'b0;
        order_err = 1'b0; ready_err = 1'b0; last_inv = -1; ack_cnt = 0;
        last_ack_cyc = 0; grant_cyc = 0;
        req_valid = 1'b1;
        req_type  = 2'(kind);
        req_node  = NW'(node);
        req_block = BW'(blk);
        req_data  = d;
        @(posedge clk);
        #1;
        req_valid = 1'b0;

        if (kind == 2) begin
            repeat (3) @(negedge clk);
            #1;
            chk(!obs_any, legal_wb ? "R8 owner write-back issues no command"
                                   : "R9 stray write-back issues no command", obs_any, 0);
            if (legal_wb) begin
                m_mem[blk] = d; m_state[blk] = 0; m_bits[blk] = '0;
            end
            return;
        end

        busy = 1'b1;
        if (kind == 0) begin
            exp_gt = 3;
            if (st == 2) begin
                exp_fk = 1; m_mem[blk] = cval[owner][blk]; tag = "R6";
            end else tag = "R2";
        end else begin
            exp_gt = 4;
            if (st == 1) begin
                exp_inv = bits & ~me; tag = (exp_inv != 0) ? "R4" : "R3";
            end else if (st == 2) begin
                exp_fk = 2; m_mem[blk] = cval[owner][blk]; tag = "R7";
            end else tag = "R3";
        end
        exp_gd = m_mem[blk];

        n = 0;
        while (!obs_grant && n < 60) begin
            @(negedge clk);
            #1;
            n++;
        end
        busy = 1'b0;

        chk(obs_grant, {tag, " grant arrives"}, obs_grant, 1);
        chk(obs_gtype == exp_gt && obs_gnode == node, {tag, " grant kind/node"},
            obs_gtype * 16 + obs_gnode, exp_gt * 16 + node);
        chk(obs_gdata == exp_gd, {tag, " grant data"}, obs_gdata, exp_gd);
        chk(obs_inv == exp_inv, "R4 invalidate set", obs_inv, exp_inv);
        chk(!order_err, "R4 invalidate order", order_err, 0);
        chk(obs_fetch == exp_fk && (exp_fk == 0 || obs_fnode == owner),
            exp_fk == 2 ? "R7 fetch-invalidate" : "R6 fetch", obs_fetch, exp_fk);
        chk(!ready_err, "R10 ready held low while busy", ready_err, 0);
        if (exp_inv != 0) begin
            chk(ack_cnt == $countones(exp_inv), "R5 all acks collected",
                ack_cnt, $countones(exp_inv));
            chk(grant_cyc > last_ack_cyc, "R5 grant after last ack", grant_cyc, last_ack_cyc + 1);
        end

        if (kind == 0) begin
            m_state[blk] = 1; m_bits[blk] = bits | me;
        end else begin
            m_state[blk] = 2; m_bits[blk] = me; cval[node][blk] = d;
        end
    endtask

    initial begin
        logic [15:0] lf = 16'hACE1;
        for (int b = 0; b < BLOCKS; b++) begin
            m_state[b] = 0; m_bits[b] = '0; m_mem[b] = '0;
            for (int n = 0; n < NODES; n++) cval[n][b] = '0;
        end
        busy = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(cmd_valid == 1'b0, "R1 no command after reset", cmd_valid, 0);

        // directed walk through every directory transition on block 0
        txn(0, 0, 0, '0);          // R1/R2 uncached read returns 0
        txn(0, 1, 0, '0);          // R2 shared read
        txn(1, 2, 0, 16'h1234);    // R4/R5 invalidate nodes 0 and 1
        txn(0, 3, 0, '0);          // R6 fetch from node 2
        txn(1, 1, 0, 16'h5678);    // R4 both old owner and reader invalidated
        txn(1, 0, 0, 16'h9abc);    // R7 fetch-invalidate from node 1
        txn(2, 2, 0, 16'hdead);    // R9 stray write-back
        txn(2, 0, 0, 16'h9abc);    // R8 owner write-back
        txn(0, 3, 0, '0);          // read sees written-back data
        txn(1, 3, 3, 16'h0f0f);    // R3 uncached write

        for (int i = 0; i < 800; i++) begin
            int kind, node, blk;
            logic [DATA_W-1:0] d;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            kind = (lf[1:0] == 2'd3) ? 0 : int'(lf[1:0]);
            node = int'(lf[3:2]);
            blk  = int'(lf[6:4]);
            d    = lf ^ 16'h5a5a;
            if (kind == 0 && m_bits[blk][node]) continue;
            if (kind == 1 && m_state[blk] == 2 && m_bits[blk][node]) continue;
            if (kind == 2 && m_state[blk] == 2 && m_bits[blk][node]) d = cval[node][blk];
            txn(kind, node, blk, d);
        end

        summary();
        $finish;
    end

endmodule